// File: doc/BRIEF.md
# Incremental Encoder Position and Velocity Tracker

This block turns the two phase signals and the index signal of an incremental rotary or linear encoder into a wrapped position count and a signed velocity figure. All three pins are resynchronised to the system clock through a two-stage flop chain. Each newly sampled phase pair is then compared with the previous one. That comparison gives a single step forward, a single step backward, no movement, or an illegal jump where both phases moved in the same sample.

A free-running window timer sums the signed steps seen during a programmable number of clocks. At the end of each window it latches the total. Four sticky event flags record index pulses, window ends, reversals of direction and illegal jumps. Each flag can be routed to one interrupt line through its own enable bit. Software sets up the block and reads the results through a small synchronous register port with a combinational read path.

Register map (3-bit address, 32-bit data):

| Address | Register | Contents |
|---|---|---|
| 0 | control | bit0 run, bit1 count on every phase edge, bit2 clear position on index |
| 1 | limit | position limit |
| 2 | position | current position; writable |
| 3 | window | window length in clocks; a write restarts the window |
| 4 | speed | latched signed speed, sign-extended |
| 5 | events | bit0 index, bit1 window end, bit2 reversal, bit3 illegal jump; write 1 to clear |
| 6 | interrupt enables | one bit per event flag, same bit positions as the events register |
| 7 | state | bit0 current direction, 1 = backward |

Top module: `quad_encoder_if`

## Requirements
- R1: After reset, control, position, events, speed, interrupt enables and state read 0, limit reads 0xFFFF, and irq is low.
- R2: With control bits 0 and 1 both set, every sampled change of exactly one phase moves position by one. Taking {A,B}, the sequence 00,10,11,01,00 counts up and the opposite sequence counts down.
- R3: With control bit 1 clear, only changes of phase A move the position. A change of phase B alone leaves position unchanged, so one full forward cycle adds 2.
- R4: Counting up from the limit gives 0, counting down from 0 gives the limit, and position never exceeds the limit.
- R5: When both phases change in the same sample, position is unchanged and event bit3 is set.
- R6: The stored direction resets to forward and reads in state bit0. Every legal single-phase change updates it, and event bit2 is set when that change runs opposite to the stored direction.
- R7: A rising edge on the index input sets event bit0. If control bit2 is set, position becomes 0 on that edge; otherwise position is unchanged.
- R8: The window timer sums +1 for each upward count and -1 for each downward count over a window of N clocks, where N is the window register value (0 acts as 1). At the end of the window it latches the sum to the speed register and sets event bit1. Writing the window register restarts the timer with an empty sum.
- R9: Writing a 1 to an event bit clears it, writing a 0 leaves it unchanged, and a new event in the same cycle as its clear leaves the bit set.
- R10: irq is high exactly when some event bit is set and its interrupt enable bit is 1.
- R11: With control bit0 clear, phase and index activity changes neither position nor any event bit, and the window timer does not run.
- R12: A write to position loads the written value, or 0 if that value exceeds the limit. A write to the limit clears position when position exceeds the new limit.
- R13: Single-phase changes arriving on consecutive clocks are all counted, and each one reaches the position register three clocks after it appears at the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_idx | input | 1 | Encoder index, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties check, on every clock, that position stays within the limit, that an illegal jump leaves position alone, that an index clear forces zero, and that counting steps are mutually exclusive. They also check that the window timer stays below its length and empties its sum on expiry, and that event bits stay set until cleared and that a set wins over a clear. Only the directed scenarios can show the decoded meaning of the phase sequences, namely which direction counts up and which edges count in the A-edge mode. The same is true of the exact window length and latched speed, the index behaviour in both settings, the interrupt gating by the enable bits, and the three-clock latency with edges on consecutive clocks.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  localparam int QE_ADDR_W = 3;

  localparam logic [QE_ADDR_W-1:0] QE_CTRL   = 3'd0;
  localparam logic [QE_ADDR_W-1:0] QE_POSMAX = 3'd1;
  localparam logic [QE_ADDR_W-1:0] QE_POS    = 3'd2;
  localparam logic [QE_ADDR_W-1:0] QE_VPER   = 3'd3;
  localparam logic [QE_ADDR_W-1:0] QE_VEL    = 3'd4;
  localparam logic [QE_ADDR_W-1:0] QE_FLAGS  = 3'd5;
  localparam logic [QE_ADDR_W-1:0] QE_MASK   = 3'd6;
  localparam logic [QE_ADDR_W-1:0] QE_STAT   = 3'd7;

  localparam int QE_CTRL_W   = 3;
  localparam int QE_C_EN     = 0;
  localparam int QE_C_QUAD   = 1;
  localparam int QE_C_IDXRST = 2;

  localparam int QE_FLAG_N = 4;
  localparam int QE_F_IDX  = 0;
  localparam int QE_F_VEL  = 1;
  localparam int QE_F_DIR  = 2;
  localparam int QE_F_ERR  = 3;

  // Result of comparing two consecutive {A,B} samples.
  typedef struct packed {
    logic valid;   // exactly one phase moved
    logic err;     // both phases moved
    logic fwd;     // direction of a valid move
    logic a_edge;  // phase A was the one that moved
  } qe_step_t;

  function automatic qe_step_t qe_classify(input logic [1:0] prev_ab,
                                           input logic [1:0] cur_ab);
    qe_step_t s;
    logic da, db;
    da       = prev_ab[1] ^ cur_ab[1];
    db       = prev_ab[0] ^ cur_ab[0];
    s.valid  = da ^ db;
    s.err    = da & db;
    // A leading B: new A differs from old B
    s.fwd    = cur_ab[1] ^ prev_ab[0];
    s.a_edge = da & ~db;
    return s;
  endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= '0;
          else        stg[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= '0;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/qenc_track.sv
module qenc_track
  import qenc_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             quad4x,
  input  logic             idx_rst_en,
  input  logic [1:0]       ab_s,
  input  logic             idx_s,
  input  logic [POS_W-1:0] pos_max,
  input  logic             pos_wr,
  input  logic [POS_W-1:0] pos_wdata,
  input  logic             max_wr,
  input  logic [POS_W-1:0] max_wdata,
  output logic [POS_W-1:0] pos,
  output logic             dir_rev,
  output logic             ev_up,
  output logic             ev_dn,
  output logic             ev_err,
  output logic             ev_idx,
  output logic             ev_dirchg
);

  localparam logic [POS_W-1:0] ONE_P = POS_W'(1);

  logic [1:0]       ab_q;
  logic             idx_q;
  logic [POS_W-1:0] pos_nxt;
  qe_step_t         stp;
  logic             counts;

  function automatic logic [POS_W-1:0] wrap_inc(input logic [POS_W-1:0] p,
                                                input logic [POS_W-1:0] m);
    return (p >= m) ? '0 : p + ONE_P;
  endfunction

  function automatic logic [POS_W-1:0] wrap_dec(input logic [POS_W-1:0] p,
                                                input logic [POS_W-1:0] m);
    return (p == '0) ? m : p - ONE_P;
  endfunction

  assign stp    = qe_classify(ab_q, ab_s);
  assign counts = stp.valid & (quad4x | stp.a_edge);

  assign ev_up     = en & counts & stp.fwd;
  assign ev_dn     = en & counts & ~stp.fwd;
  assign ev_err    = en & stp.err;
  assign ev_idx    = en & idx_s & ~idx_q;
  assign ev_dirchg = en & stp.valid & (stp.fwd == dir_rev);

  always_comb begin
    pos_nxt = pos;
    if (pos_wr)                   pos_nxt = (pos_wdata > pos_max) ? '0 : pos_wdata;
    else if (max_wr)              pos_nxt = (pos > max_wdata) ? '0 : pos;
    else if (ev_idx && idx_rst_en) pos_nxt = '0;
    else if (ev_up)               pos_nxt = wrap_inc(pos, pos_max);
    else if (ev_dn)               pos_nxt = wrap_dec(pos, pos_max);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_q    <= '0;
      idx_q   <= 1'b0;
      pos     <= '0;
      dir_rev <= 1'b0;
    end else begin
      ab_q  <= ab_s;
      idx_q <= idx_s;
      pos   <= pos_nxt;
      if (en && stp.valid) dir_rev <= ~stp.fwd;
    end
  end

  logic no_override;
  assign no_override = !pos_wr && !max_wr && !(ev_idx && idx_rst_en);

  AST_POS_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= pos_max); // R4
  AST_JUMP_HOLDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_err && no_override) |=> pos == $past(pos)); // R5
  AST_INDEX_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_idx && idx_rst_en && !pos_wr && !max_wr) |=> pos == '0); // R7
  AST_ONE_STEP_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_up, ev_dn, ev_err})); // R2
  AST_UP_MOVES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_up && no_override && pos < pos_max) |=> pos == $past(pos) + ONE_P); // R2

endmodule

// File: rtl/qenc_velocity.sv
module qenc_velocity #(
  parameter int TMR_W = 16,
  parameter int VEL_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    restart,
  input  logic [TMR_W-1:0]        period,
  input  logic                    ev_up,
  input  logic                    ev_dn,
  output logic signed [VEL_W-1:0] vel,
  output logic                    ev_expire
);

  localparam logic [TMR_W:0]              ONE_T = (TMR_W+1)'(1);
  localparam logic [TMR_W-1:0]            INC_T = TMR_W'(1);
  localparam logic signed [VEL_W-1:0]     ONE_V = VEL_W'(1);

  logic [TMR_W-1:0]        tmr;
  logic signed [VEL_W-1:0] acc, acc_nxt;
  logic                    at_end;

  assign at_end    = ({1'b0, tmr} + ONE_T) >= {1'b0, period};
  assign ev_expire = en & at_end & ~restart;

  always_comb begin
    acc_nxt = acc;
    if (ev_up)      acc_nxt = acc + ONE_V;
    else if (ev_dn) acc_nxt = acc - ONE_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0;
      acc <= '0;
      vel <= '0;
    end else if (restart || !en) begin
      tmr <= '0;
      acc <= '0;
    end else if (at_end) begin
      vel <= acc_nxt;
      acc <= '0;
      tmr <= '0;
    end else begin
      tmr <= tmr + INC_T;
      acc <= acc_nxt;
    end
  end

  AST_TIMER_BELOW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (period > INC_T) |-> tmr < period); // R8
  AST_EXPIRY_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_expire |=> (tmr == '0 && acc == '0)); // R8
  AST_IDLE_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> tmr == '0); // R11

endmodule

// File: rtl/qenc_regs.sv
module qenc_regs
  import qenc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int POS_W  = 16,
  parameter int TMR_W  = 16,
  parameter int VEL_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [QE_ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  output logic                    irq,
  input  logic [POS_W-1:0]        pos,
  input  logic signed [VEL_W-1:0] vel,
  input  logic                    dir_rev,
  input  logic [QE_FLAG_N-1:0]    flag_set,
  output logic                    en,
  output logic                    quad4x,
  output logic                    idx_rst_en,
  output logic [POS_W-1:0]        pos_max,
  output logic [TMR_W-1:0]        period,
  output logic                    pos_wr,
  output logic                    max_wr,
  output logic                    per_wr
);

  logic [QE_CTRL_W-1:0] ctrl;
  logic [QE_FLAG_N-1:0] flags, mask, flag_clr;
  logic                 ctrl_wr, mask_wr;

  assign ctrl_wr  = reg_we && (reg_addr == QE_CTRL);
  assign mask_wr  = reg_we && (reg_addr == QE_MASK);
  assign pos_wr   = reg_we && (reg_addr == QE_POS);
  assign max_wr   = reg_we && (reg_addr == QE_POSMAX);
  assign per_wr   = reg_we && (reg_addr == QE_VPER);
  assign flag_clr = (reg_we && reg_addr == QE_FLAGS) ? reg_wdata[QE_FLAG_N-1:0] : '0;

  assign en         = ctrl[QE_C_EN];
  assign quad4x     = ctrl[QE_C_QUAD];
  assign idx_rst_en = ctrl[QE_C_IDXRST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      pos_max <= '1;
      period  <= '1;
      mask    <= '0;
    end else begin
      if (ctrl_wr) ctrl    <= reg_wdata[QE_CTRL_W-1:0];
      if (max_wr)  pos_max <= reg_wdata[POS_W-1:0];
      if (per_wr)  period  <= reg_wdata[TMR_W-1:0];
      if (mask_wr) mask    <= reg_wdata[QE_FLAG_N-1:0];
    end
  end

  genvar f;
  generate
    for (f = 0; f < QE_FLAG_N; f++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           flags[f] <= 1'b0;
        else if (flag_set[f]) flags[f] <= 1'b1;
        else if (flag_clr[f]) flags[f] <= 1'b0;
      end
    end
  endgenerate

  assign irq = |(flags & mask);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      QE_CTRL:   reg_rdata = DATA_W'(ctrl);
      QE_POSMAX: reg_rdata = DATA_W'(pos_max);
      QE_POS:    reg_rdata = DATA_W'(pos);
      QE_VPER:   reg_rdata = DATA_W'(period);
      QE_VEL:    reg_rdata = DATA_W'(vel);
      QE_FLAGS:  reg_rdata = DATA_W'(flags);
      QE_MASK:   reg_rdata = DATA_W'(mask);
      default:   reg_rdata = DATA_W'(dir_rev);
    endcase
  end

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr))); // R9
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_set) |=> ((flags & $past(flag_set)) == $past(flag_set))); // R9
  AST_QUIET_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq); // R10

endmodule

// File: rtl/quad_encoder_if.sv
module quad_encoder_if
  import qenc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int POS_W    = 16,
  parameter int TMR_W    = 16,
  parameter int VEL_W    = 16,
  parameter int SYNC_STG = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enc_a,
  input  logic                 enc_b,
  input  logic                 enc_idx,
  input  logic                 reg_we,
  input  logic [QE_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 irq
);

  logic [2:0]              pins_s;
  logic                    en, quad4x, idx_rst_en;
  logic [POS_W-1:0]        pos, pos_max;
  logic [TMR_W-1:0]        period;
  logic                    pos_wr, max_wr, per_wr;
  logic                    dir_rev;
  logic                    ev_up, ev_dn, ev_err, ev_idx, ev_dirchg, ev_expire;
  logic signed [VEL_W-1:0] vel;
  logic [QE_FLAG_N-1:0]    flag_set;

  qenc_sync #(.WIDTH(3), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({enc_a, enc_b, enc_idx}),
    .q(pins_s)
  );

  qenc_track #(.POS_W(POS_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .en(en), .quad4x(quad4x), .idx_rst_en(idx_rst_en),
    .ab_s(pins_s[2:1]), .idx_s(pins_s[0]),
    .pos_max(pos_max),
    .pos_wr(pos_wr), .pos_wdata(reg_wdata[POS_W-1:0]),
    .max_wr(max_wr), .max_wdata(reg_wdata[POS_W-1:0]),
    .pos(pos), .dir_rev(dir_rev),
    .ev_up(ev_up), .ev_dn(ev_dn), .ev_err(ev_err),
    .ev_idx(ev_idx), .ev_dirchg(ev_dirchg)
  );

  qenc_velocity #(.TMR_W(TMR_W), .VEL_W(VEL_W)) u_vel (
    .clk(clk), .rst_n(rst_n),
    .en(en), .restart(per_wr), .period(period),
    .ev_up(ev_up), .ev_dn(ev_dn),
    .vel(vel), .ev_expire(ev_expire)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[QE_F_IDX] = ev_idx;
    flag_set[QE_F_VEL] = ev_expire;
    flag_set[QE_F_DIR] = ev_dirchg;
    flag_set[QE_F_ERR] = ev_err;
  end

  qenc_regs #(.DATA_W(DATA_W), .POS_W(POS_W), .TMR_W(TMR_W), .VEL_W(VEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq),
    .pos(pos), .vel(vel), .dir_rev(dir_rev), .flag_set(flag_set),
    .en(en), .quad4x(quad4x), .idx_rst_en(idx_rst_en),
    .pos_max(pos_max), .period(period),
    .pos_wr(pos_wr), .max_wr(max_wr), .per_wr(per_wr)
  );

  AST_DISABLED_NO_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (flag_set == '0)); // R11

endmodule

// File: tb/test_quad_encoder_if.sv
module test_quad_encoder_if;

  localparam logic [2:0] A_CTRL = 3'd0, A_MAX = 3'd1, A_POS = 3'd2, A_WIN = 3'd3,
                         A_VEL = 3'd4, A_EVT = 3'd5, A_ENA = 3'd6, A_STAT = 3'd7;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  int ph = 0;
  logic [15:0] mpos = '0, mmax = 16'hFFFF;
  bit quad = 1'b1;

  always #4 clk = ~clk;

  quad_encoder_if i_quad_encoder_if (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [1:0] gray(input int k);
    case (k & 3)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic settle; repeat (4) @(negedge clk); endtask

  task automatic step(input bit fwd, input bit live);
    logic [1:0] o, n;
    o  = gray(ph);
    ph = fwd ? (ph + 1) & 3 : (ph + 3) & 3;
    n  = gray(ph);
    @(negedge clk); {enc_a, enc_b} = n;
    if (live && (quad || o[1] != n[1]))
      mpos = fwd ? ((mpos >= mmax) ? 16'h0 : mpos + 16'h1)
                 : ((mpos == 16'h0) ? mmax : mpos - 16'h1);
  endtask

  task automatic jump;
    ph = (ph + 2) & 3;
    @(negedge clk); {enc_a, enc_b} = gray(ph);
    settle();
  endtask

  task automatic pulse_index;
    @(negedge clk); enc_idx = 1'b1;
    repeat (3) @(negedge clk); enc_idx = 1'b0;
    settle();
  endtask

  task automatic chk_pos(input string tag);
    logic [31:0] v;
    rd(A_POS, v); chk(tag, v, {16'h0, mpos});
  endtask

  task automatic chk_evt(input string tag, input int bitn, input logic exp);
    logic [31:0] v;
    rd(A_EVT, v); chk(tag, {31'h0, v[bitn]}, {31'h0, exp});
  endtask

  task automatic wait_window(output logic [31:0] speed);
    logic [31:0] v;
    int w = 0;
    do begin rd(A_EVT, v); w++; end while (!v[1] && w < 2000);
    rd(A_VEL, speed);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_CTRL, v); chk("R1 control", v, 32'h0);
    rd(A_POS, v);  chk("R1 position", v, 32'h0);
    rd(A_EVT, v);  chk("R1 events", v, 32'h0);
    rd(A_VEL, v);  chk("R1 speed", v, 32'h0);
    rd(A_ENA, v);  chk("R1 enables", v, 32'h0);
    rd(A_STAT, v); chk("R1 direction", v, 32'h0);
    rd(A_MAX, v);  chk("R1 limit", v, 32'h0000FFFF);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_count_4x;
    logic [31:0] v;
    wr(A_CTRL, 32'h3);
    for (int i = 0; i < 6; i++) begin step(1'b1, 1'b1); settle(); end
    chk_pos("R2 six up");
    chk_evt("R6 no reversal yet", 2, 1'b0);
    for (int i = 0; i < 2; i++) begin step(1'b0, 1'b1); settle(); end
    chk_pos("R2 two down");
    chk_evt("R6 reversal flag", 2, 1'b1);
    rd(A_STAT, v); chk("R6 direction backward", v, 32'h1);
    wr(A_EVT, 32'hF);
    rd(A_EVT, v); chk("R9 clear all", v, 32'h0);
  endtask

  task automatic t_fast;
    logic [31:0] v;
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1);
    @(negedge clk);
    @(negedge clk);
    settle();
    chk_pos("R13 back-to-back edges");
    rd(A_STAT, v); chk("R6 direction forward", v, 32'h0);
  endtask

  task automatic t_a_edge_mode;
    wr(A_CTRL, 32'h1); quad = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b1); settle();
      chk_pos("R3 A-edge mode step");
    end
    wr(A_CTRL, 32'h3); quad = 1'b1;
  endtask

  task automatic t_wrap;
    wr(A_MAX, 32'd9); mmax = 16'd9;
    if (mpos > 16'd9) mpos = 16'h0;
    chk_pos("R12 limit write trims position");
    wr(A_POS, 32'd0); mpos = 16'h0;
    step(1'b0, 1'b1); settle();
    chk_pos("R4 down from zero");
    step(1'b1, 1'b1); settle();
    chk_pos("R4 up from limit");
    wr(A_POS, 32'd7); mpos = 16'd7;
    chk_pos("R12 load in range");
    wr(A_POS, 32'd12); mpos = 16'd0;
    chk_pos("R12 load above limit");
    wr(A_MAX, 32'hFFFF); mmax = 16'hFFFF;
  endtask

  task automatic t_jump;
    wr(A_EVT, 32'hF);
    wr(A_POS, 32'd40); mpos = 16'd40;
    jump();
    chk_pos("R5 jump keeps position");
    chk_evt("R5 jump flag", 3, 1'b1);
  endtask

  task automatic t_index;
    wr(A_EVT, 32'hF);
    pulse_index();
    chk_evt("R7 index flag", 0, 1'b1);
    chk_pos("R7 no clear when off");
    wr(A_CTRL, 32'h7);
    wr(A_EVT, 32'hF);
    pulse_index(); mpos = 16'h0;
    chk_pos("R7 clear on index");
    wr(A_CTRL, 32'h3);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(A_EVT, 32'hF);
    wr(A_ENA, 32'h0);
    jump();
    chk("R10 masked event", {31'h0, irq}, 32'h0);
    wr(A_ENA, 32'h8);
    chk("R10 enabled event", {31'h0, irq}, 32'h1);
    wr(A_ENA, 32'h1);
    chk("R10 other enable", {31'h0, irq}, 32'h0);
    wr(A_ENA, 32'h8);
    wr(A_EVT, 32'h0);
    rd(A_EVT, v); chk("R9 zero write keeps", {28'h0, v[3:0]} & 32'h8, 32'h8);
    wr(A_EVT, 32'h4);
    rd(A_EVT, v); chk("R9 other bit keeps", {28'h0, v[3:0]} & 32'h8, 32'h8);
    wr(A_EVT, 32'h8);
    rd(A_EVT, v); chk("R9 clear one", {28'h0, v[3:0]} & 32'h8, 32'h0);
    chk("R10 irq drops", {31'h0, irq}, 32'h0);
    wr(A_ENA, 32'h0);
  endtask

  task automatic t_velocity;
    logic [31:0] v;
    wr(A_EVT, 32'hF);
    wr(A_WIN, 32'd200);
    for (int i = 0; i < 5; i++) begin step(1'b1, 1'b1); settle(); end
    wait_window(v); chk("R8 forward speed", v, 32'd5);
    wr(A_EVT, 32'hF);
    for (int i = 0; i < 3; i++) begin step(1'b0, 1'b1); settle(); end
    wait_window(v); chk("R8 backward speed", v, 32'hFFFFFFFD);
    wr(A_EVT, 32'hF);
    wr(A_WIN, 32'd50);
    repeat (48) @(negedge clk);
    rd(A_EVT, v); chk("R8 window not ended", {31'h0, v[1]}, 32'h0);
    rd(A_EVT, v); chk("R8 window ends on time", {31'h0, v[1]}, 32'h1);
    rd(A_VEL, v); chk("R8 still speed", v, 32'h0);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    wr(A_CTRL, 32'h0);
    wr(A_EVT, 32'hF);
    for (int i = 0; i < 3; i++) begin step(1'b0, 1'b0); settle(); end
    jump();
    pulse_index();
    repeat (60) @(negedge clk);
    chk_pos("R11 no counting when off");
    rd(A_EVT, v); chk("R11 no events when off", v, 32'h0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count_4x();
    t_fast();
    t_a_edge_mode();
    t_wrap();
    t_jump();
    t_index();
    t_irq();
    t_velocity();
    t_disabled();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule